// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a large number of level-sensitive interrupt sources and folds them onto a smaller set of parent interrupt lines. Sources are grouped eight at a time into a combiner. Each combiner has a private enable byte and drives one parent line. That line is high while at least one enabled source of the combiner is high. Four combiners are packed into the four byte lanes of a 32-bit register group, and consecutive groups sit 0x10 bytes apart in the address map.

Software changes enables only through two write-one-to-act addresses, one that sets enables and one that clears them. No read-modify-write is ever needed, and two agents touching different bits cannot race. Software then reads a pending word, which is the live input level masked by the enables, to see which enabled sources of a group are active. The raw levels and the enable word can also be read back. The register port is a plain single-cycle request port with a word address.

Top module: `irq_combiner`

## Requirements
- R1: After the active-low reset, every enable bit is 0, every parent line is 0, and read data is 0.
- R2: A write to word offset 0 (byte offset 0x0) of a group sets each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R3: A write to word offset 1 (byte offset 0x4) of a group clears each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: Source k (0..7) of combiner n is global input n*8+k. It is controlled and reported at bit 8*(n mod 4)+k of group n/4, and that group's byte address is (n/4)*0x10. Bits 7:4 of the byte address select the group and bits 3:2 select the word.
- R5: A read at word offset 0 returns the group's enable word. Read data appears on the read-data output one cycle after the request and holds until the next read.
- R6: A read at word offset 3 (byte offset 0xC) returns the input levels ANDed with the enables, taken at the request cycle. Nothing is latched, so a source that drops no longer reads as pending.
- R7: Parent line n is registered. In the cycle after an edge it equals the OR, over combiner n's eight sources, of input level AND enable as they stood before that edge.
- R8: A read at word offset 2 (byte offset 0x8) returns the raw input levels of the group, whatever the enables.
- R9: The following have no effect on any enable: writes to word offsets 2 and 3, and any access to a group index at or above the number of groups. Reads at word offset 1 and reads of such groups return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_COMB*8 | Level-sensitive interrupt sources |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1:2) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| parent_o | output | NUM_COMB | One parent interrupt line per combiner |

## Verification
The two functions that can land on the same edge are an enable update from the register port and a change of source levels. Each parent line must then reflect the old enables and the sampled inputs for one cycle, and the updated enables from the next cycle on. The bench provokes this in directed steps: it raises a source together with a set-write for it, and drops the enable of a high source while a neighbour rises. A long random phase then drives new source levels and a random access on every cycle. A behavioural model updated on each rising edge predicts the parent lines and read data, and these are compared at every falling edge.

// File: rtl/irq_comb_pkg.sv
`timescale 1ns/1ps
package irq_comb_pkg;
  localparam int unsigned SRC_PER_COMB  = 8;
  localparam int unsigned LANES_PER_GRP = 4;
  localparam int unsigned GRP_BITS      = SRC_PER_COMB * LANES_PER_GRP;

  typedef enum logic [1:0] {
    OFF_EN_SET = 2'd0,
    OFF_EN_CLR = 2'd1,
    OFF_RAW    = 2'd2,
    OFF_PEND   = 2'd3
  } reg_off_e;
endpackage

// File: rtl/irq_comb_decode.sv
`timescale 1ns/1ps
module irq_comb_decode
  import irq_comb_pkg::*;
#(
  parameter int unsigned NUM_GRP = 5,
  parameter int unsigned GIDX_W  = 4
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic [GIDX_W-1:0]  gidx_i,
  input  reg_off_e           off_i,
  output logic [NUM_GRP-1:0] set_o,
  output logic [NUM_GRP-1:0] clr_o,
  output logic               rd_o,
  output logic               hit_o
);
  logic wr;

  assign hit_o = (int'(gidx_i) < int'(NUM_GRP));
  assign wr    = req_i & we_i & hit_o;
  assign rd_o  = req_i & ~we_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_sel
    logic sel;
    assign sel      = wr & (gidx_i == GIDX_W'(g));
    assign set_o[g] = sel & (off_i == OFF_EN_SET);
    assign clr_o[g] = sel & (off_i == OFF_EN_CLR);
  end
endmodule

// File: rtl/irq_comb_lane.sv
`timescale 1ns/1ps
module irq_comb_lane
  import irq_comb_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SRC_PER_COMB-1:0] src_i,
  input  logic                    set_i,
  input  logic                    clr_i,
  input  logic [SRC_PER_COMB-1:0] wmask_i,
  output logic [SRC_PER_COMB-1:0] en_o,
  output logic [SRC_PER_COMB-1:0] pend_o,
  output logic                    parent_o
);
  logic [SRC_PER_COMB-1:0] en_q;
  logic                    parent_q;

  // set and clear never arrive together: they decode from distinct offsets
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (set_i) begin
      en_q <= en_q | wmask_i;
    end else if (clr_i) begin
      en_q <= en_q & ~wmask_i;
    end
  end

  assign pend_o = src_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) parent_q <= 1'b0;
    else         parent_q <= |pend_o;
  end

  assign en_o     = en_q;
  assign parent_o = parent_q;
endmodule

// File: rtl/irq_comb_group.sv
`timescale 1ns/1ps
module irq_comb_group
  import irq_comb_pkg::*;
#(
  parameter int unsigned LANES  = LANES_PER_GRP,
  localparam int unsigned USED_W = LANES * SRC_PER_COMB
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [USED_W-1:0]   src_i,
  input  logic                set_i,
  input  logic                clr_i,
  input  logic [USED_W-1:0]   wdata_i,
  output logic [GRP_BITS-1:0] en_o,
  output logic [GRP_BITS-1:0] raw_o,
  output logic [GRP_BITS-1:0] pend_o,
  output logic [LANES-1:0]    parent_o
);
  logic [USED_W-1:0] en_used;
  logic [USED_W-1:0] pend_used;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    irq_comb_lane i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_i[l*SRC_PER_COMB +: SRC_PER_COMB]),
      .set_i    (set_i),
      .clr_i    (clr_i),
      .wmask_i  (wdata_i[l*SRC_PER_COMB +: SRC_PER_COMB]),
      .en_o     (en_used[l*SRC_PER_COMB +: SRC_PER_COMB]),
      .pend_o   (pend_used[l*SRC_PER_COMB +: SRC_PER_COMB]),
      .parent_o (parent_o[l])
    );
  end

  if (USED_W < GRP_BITS) begin : g_pad
    assign en_o   = {{(GRP_BITS-USED_W){1'b0}}, en_used};
    assign raw_o  = {{(GRP_BITS-USED_W){1'b0}}, src_i};
    assign pend_o = {{(GRP_BITS-USED_W){1'b0}}, pend_used};
  end else begin : g_full
    assign en_o   = en_used;
    assign raw_o  = src_i;
    assign pend_o = pend_used;
  end
endmodule

// File: rtl/irq_comb_rdmux.sv
`timescale 1ns/1ps
module irq_comb_rdmux
  import irq_comb_pkg::*;
#(
  parameter int unsigned NUM_GRP = 5,
  parameter int unsigned GIDX_W  = 4,
  localparam int unsigned WW     = NUM_GRP * GRP_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic                hit_i,
  input  logic [GIDX_W-1:0]   gidx_i,
  input  reg_off_e            off_i,
  input  logic [WW-1:0]       en_i,
  input  logic [WW-1:0]       raw_i,
  input  logic [WW-1:0]       pend_i,
  output logic [GRP_BITS-1:0] rdata_o
);
  logic [GRP_BITS-1:0] word_d;
  logic [GRP_BITS-1:0] rdata_q;
  logic [GRP_BITS-1:0] en_w, raw_w, pend_w;

  // word select per group; out-of-range index forced to zero below
  always_comb begin
    en_w   = '0;
    raw_w  = '0;
    pend_w = '0;
    for (int g = 0; g < int'(NUM_GRP); g++) begin
      if (gidx_i == GIDX_W'(g)) begin
        en_w   = en_i[g*GRP_BITS +: GRP_BITS];
        raw_w  = raw_i[g*GRP_BITS +: GRP_BITS];
        pend_w = pend_i[g*GRP_BITS +: GRP_BITS];
      end
    end
  end

  always_comb begin
    word_d = '0;
    if (hit_i) begin
      unique case (off_i)
        OFF_EN_SET: word_d = en_w;
        OFF_EN_CLR: word_d = '0;
        OFF_RAW:    word_d = raw_w;
        OFF_PEND:   word_d = pend_w;
        default:    word_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= word_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_combiner.sv
`timescale 1ns/1ps
module irq_combiner
  import irq_comb_pkg::*;
#(
  parameter int unsigned NUM_COMB = 20,
  parameter int unsigned ADDR_W   = 8,
  localparam int unsigned NUM_SRC = NUM_COMB * SRC_PER_COMB,
  localparam int unsigned NUM_GRP = (NUM_COMB + LANES_PER_GRP - 1) / LANES_PER_GRP,
  localparam int unsigned GIDX_W  = ADDR_W - 4,
  localparam int unsigned WW      = NUM_GRP * GRP_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  irq_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:2]   addr_i,
  input  logic [GRP_BITS-1:0] wdata_i,
  output logic [GRP_BITS-1:0] rdata_o,
  output logic [NUM_COMB-1:0] parent_o
);
  logic [GIDX_W-1:0]  gidx;
  reg_off_e           off;
  logic [NUM_GRP-1:0] set_stb, clr_stb;
  logic               rd_stb, grp_hit;
  logic [WW-1:0]      en_words, raw_words, pend_words;

  assign gidx = addr_i[ADDR_W-1:4];
  assign off  = reg_off_e'(addr_i[3:2]);

  irq_comb_decode #(
    .NUM_GRP (NUM_GRP),
    .GIDX_W  (GIDX_W)
  ) i_decode (
    .req_i  (req_i),
    .we_i   (we_i),
    .gidx_i (gidx),
    .off_i  (off),
    .set_o  (set_stb),
    .clr_o  (clr_stb),
    .rd_o   (rd_stb),
    .hit_o  (grp_hit)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    // last group may carry fewer than four combiners
    localparam int unsigned LU = (g == NUM_GRP - 1) ?
                                 (NUM_COMB - g * LANES_PER_GRP) : LANES_PER_GRP;
    irq_comb_group #(
      .LANES (LU)
    ) i_group (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (irq_i[g*GRP_BITS +: LU*SRC_PER_COMB]),
      .set_i    (set_stb[g]),
      .clr_i    (clr_stb[g]),
      .wdata_i  (wdata_i[LU*SRC_PER_COMB-1:0]),
      .en_o     (en_words[g*GRP_BITS +: GRP_BITS]),
      .raw_o    (raw_words[g*GRP_BITS +: GRP_BITS]),
      .pend_o   (pend_words[g*GRP_BITS +: GRP_BITS]),
      .parent_o (parent_o[g*LANES_PER_GRP +: LU])
    );
  end

  irq_comb_rdmux #(
    .NUM_GRP (NUM_GRP),
    .GIDX_W  (GIDX_W)
  ) i_rdmux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_stb),
    .hit_i   (grp_hit),
    .gidx_i  (gidx),
    .off_i   (off),
    .en_i    (en_words),
    .raw_i   (raw_words),
    .pend_i  (pend_words),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/irq_combiner_chk.sv
`timescale 1ns/1ps
module irq_combiner_chk #(
  parameter int unsigned NUM_COMB = 20,
  parameter int unsigned ADDR_W   = 8,
  localparam int unsigned NUM_SRC = NUM_COMB * 8,
  localparam int unsigned NUM_GRP = (NUM_COMB + 3) / 4,
  localparam int unsigned WW      = NUM_GRP * 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_SRC-1:0]  irq_i,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:2]   addr_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_COMB-1:0] parent_o,
  input logic [WW-1:0]       en_words
);
  localparam logic [WW-1:0] LANE_MASK = WW'({NUM_SRC{1'b1}});

  int unsigned         gidx;
  logic                upd, is_set, is_clr;
  logic [WW-1:0]       wide;
  logic [NUM_COMB-1:0] exp_par;

  always_comb begin
    gidx   = int'(addr_i[ADDR_W-1:4]);
    upd    = req_i & we_i & (gidx < NUM_GRP);
    is_set = upd & (addr_i[3:2] == 2'd0);
    is_clr = upd & (addr_i[3:2] == 2'd1);
    wide   = upd ? ((WW'(wdata_i) << (32 * gidx)) & LANE_MASK) : '0;
    for (int n = 0; n < int'(NUM_COMB); n++) begin
      exp_par[n] = |(irq_i[8*n +: 8] & en_words[8*n +: 8]);
    end
  end

  AST_SET_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_set |=> en_words == ($past(en_words) | $past(wide)));           // R2
  AST_CLR_ANDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_clr |=> en_words == ($past(en_words) & ~$past(wide)));          // R3
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_set || is_clr) |=> $stable(en_words));                        // R9
  AST_PARENT_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parent_o == $past(exp_par));                                       // R7
  AST_PARENT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_words == '0) |=> (parent_o == '0));                            // R7
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));                           // R5
endmodule

bind irq_combiner irq_combiner_chk #(
  .NUM_COMB (NUM_COMB),
  .ADDR_W   (ADDR_W)
) i_irq_combiner_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_i),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .parent_o (parent_o),
  .en_words (en_words)
);

// File: tb/test_irq_combiner.sv
`timescale 1ns/1ps
module test_irq_combiner;
  localparam int NC = 20;
  localparam int NS = NC * 8;
  localparam int NG = (NC + 3) / 4;
  localparam int WW = NG * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq = '0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [7:2]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] parent;

  int checks = 0;
  int fails  = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_combiner #(.NUM_COMB(NC), .ADDR_W(8)) i_irq_combiner (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .parent_o(parent)
  );

  // ---------------- reference model ----------------
  logic [WW-1:0] m_en = '0;
  logic [NC-1:0] e_par = '0;
  logic [31:0]   e_rd = '0;
  string         e_tag = "R1";

  function automatic logic [31:0] m_word(int g, int o);
    logic [WW-1:0] raw;
    raw = WW'(irq);
    if (g >= NG) return 32'h0;
    case (o)
      0: return m_en[g*32 +: 32];
      2: return raw[g*32 +: 32];
      3: return raw[g*32 +: 32] & m_en[g*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; e_par = '0; e_rd = '0; e_tag = "R1";
    end else begin
      for (int n = 0; n < NC; n++) e_par[n] = |(irq[8*n +: 8] & m_en[8*n +: 8]);
      if (req) begin
        int g, o;
        logic [WW-1:0] w;
        g = int'(addr[7:4]);
        o = int'(addr[3:2]);
        if (we) begin
          if (g < NG) begin
            w = (WW'(wdata) << (32 * g)) & WW'({NS{1'b1}});
            if (o == 0) m_en = m_en | w;       // R2
            else if (o == 1) m_en = m_en & ~w; // R3
          end
        end else begin
          e_rd = m_word(g, o);
          if (g >= NG || o == 1) e_tag = "R9";
          else if (o == 0) e_tag = "R5";
          else if (o == 2) e_tag = "R8";
          else e_tag = "R6";
        end
      end
    end
  end

  task automatic chk(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk("R7", WW'(parent), WW'(e_par));
      chk(e_tag, WW'(rdata), WW'(e_rd));
    end
  end

  // ---------------- bus tasks (called just after a falling edge) ----------------
  task automatic bus_wr(int g, int o, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = {4'(g), 2'(o)}; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(int g, int o);
    req = 1'b1; we = 1'b0; addr = {4'(g), 2'(o)};
    @(negedge clk);
    req = 1'b0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk("R1", WW'(parent), '0);
    chk("R1", WW'(rdata), '0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    @(negedge clk);

    // R1: enables all clear after reset
    for (int g = 0; g < NG; g++) begin
      bus_rd(g, 0);
      chk("R1", WW'(rdata), '0);
    end

    // R2: set only where written ones
    bus_wr(0, 0, 32'h0000_00A5);
    bus_wr(0, 0, 32'h0000_0F00);
    bus_rd(0, 0);
    chk("R2", WW'(rdata), WW'(32'h0000_0FA5));

    // R3: clear only where written ones
    bus_wr(0, 1, 32'h0000_0081);
    bus_rd(0, 0);
    chk("R3", WW'(rdata), WW'(32'h0000_0F24));
    bus_wr(0, 1, 32'hFFFF_FFFF);

    // R4: combiner 13 source 5 -> global 109, group 3 bit 13 (byte addr 0x30)
    bus_wr(3, 0, 32'h0000_2000);
    irq[109] = 1'b1;
    chk("R7", WW'(parent), '0);  // before the sampling edge
    @(negedge clk);
    chk("R4", WW'(parent), WW'(20'h0_2000));
    bus_rd(3, 3);
    chk("R4", WW'(rdata), WW'(32'h0000_2000));

    // R6: pending is not latched
    irq[109] = 1'b0;
    bus_rd(3, 3);
    chk("R6", WW'(rdata), '0);
    chk("R7", WW'(parent), '0);

    // R8: raw levels regardless of enables
    irq[40 +: 8] = 8'h5A;  // combiner 5 -> group 1 lane 1
    bus_rd(1, 2);
    chk("R8", WW'(rdata), WW'(32'h0000_5A00));
    bus_rd(1, 3);
    chk("R6", WW'(rdata), '0);
    chk("R7", WW'(parent), '0);

    // R9: writes to read-only words and absent groups change nothing
    bus_wr(1, 2, 32'hFFFF_FFFF);
    bus_wr(1, 3, 32'hFFFF_FFFF);
    bus_wr(7, 0, 32'hFFFF_FFFF);
    bus_wr(NG, 0, 32'hFFFF_FFFF);
    for (int g = 0; g < NG; g++) begin
      bus_rd(g, 0);
      chk("R9", WW'(rdata), WW'(g == 3 ? 32'h0000_2000 : 32'h0));
    end
    bus_rd(NG, 0);
    chk("R9", WW'(rdata), '0);
    bus_rd(3, 1);
    chk("R9", WW'(rdata), '0);
    chk("R9", WW'(parent), '0);

    // Same edge: set-write lands with the source rising (R7)
    irq[45] = 1'b1;
    bus_wr(1, 0, 32'h0000_2000);  // enable bit 13 = global 45
    chk("R7", WW'(parent), '0);   // old enable seen on that edge
    @(negedge clk);
    chk("R7", WW'(parent), WW'(20'h0_0020));
    // clear-write while a neighbour source rises
    irq[46] = 1'b1;
    bus_wr(1, 1, 32'h0000_2000);
    chk("R7", WW'(parent), WW'(20'h0_0020));
    @(negedge clk);
    chk("R7", WW'(parent), '0);

    // random phase: levels and accesses change every cycle
    for (int i = 0; i < 2000; i++) begin
      for (int c = 0; c < NS / 32; c++) irq[c*32 +: 32] = $urandom;
      case ($urandom % 5)
        0: begin req = 1'b0; we = 1'b0; end
        1, 2: begin req = 1'b1; we = 1'b1; addr = {4'($urandom % (NG + 1)), 2'($urandom % 2)}; wdata = $urandom; end
        default: begin req = 1'b1; we = 1'b0; addr = {4'($urandom % (NG + 1)), 2'($urandom % 4)}; end
      endcase
      @(negedge clk);
    end
    req = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R7 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule